// File: doc/BRIEF.md
# LIN Master Header Transmitter

This block opens every frame on a single-wire, wired-AND LIN bus from the master side. A one-cycle start request latches a 6-bit frame identifier and a baud selection. The block then drives the line low for a long break, releases it for a delimiter, and sends two UART-framed bytes. The first is a fixed synchronization pattern that lets slaves measure the master's bit time. The second is the identifier with two protection bits.

The transmit output is meant for an open-drain driver. A 0 is dominant and pulls the bus low. A 1 is recessive and lets the pull-up hold the bus high. While the header is in progress `busy` stays high. A single-cycle `done` marks the end of the identifier's stop bit. A new start request is accepted in that very cycle, so headers can follow each other without a gap. Bit timing comes from a divider whose three ratios are derived from the clock-frequency parameter.

Top module: `lin_master_hdr_tx`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0 and `done` is 0.
- R2: In the cycle after an accepted start, `txd` goes to 0 and stays 0 for 13 bit times. It is then 1 for `DELIM_BITS` bit times (default 1).
- R3: The delimiter is followed by the byte 0x55 in UART framing, as 10 bit times in this order: start bit 0, data bits 0 to 7 (LSB first), stop bit 1.
- R4: The synchronization byte is followed by the identifier byte in the same framing. Its bits 5:0 are the `frame_id` latched at start. Bit 6 is id0^id1^id2^id4. Bit 7 is the inverse of id1^id3^id4^id5.
- R5: One bit time lasts CLK_HZ/rate clock cycles. `baud_sel` encoding: 00 gives 2400, 01 gives 9600, and 10 and 11 both give 19200.
- R6: A start request while `busy` is 1 has no effect. Changes to `frame_id` or `baud_sel` while `busy` is 1 do not alter the header in progress.
- R7: `busy` stays 1 for exactly 34 bit times with the default delimiter. In the following cycle `done` is 1 for a single cycle and `busy` is 0.
- R8: A start request present in the `done` cycle is accepted. The next header begins in the following cycle. A start in the last `busy` cycle is ignored.
- R9: Whenever `busy` is 0, `txd` is 1 (recessive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_sel | input | 2 | Bit-rate select, sampled on an accepted start |
| start | input | 1 | Header request, sampled each clock |
| frame_id | input | 6 | Frame identifier, sampled on an accepted start |
| txd | output | 1 | Line level to the open-drain driver (0 dominant) |
| busy | output | 1 | High while a header is being sent |
| done | output | 1 | One-cycle pulse after the identifier stop bit |

## Verification
Two events can fall in the same cycle: the end of one header and the acceptance of the next. In that cycle `done` is high and a new start request is present. The bench detects `busy` at mid-cycle and counts cycles to reach the exact last busy cycle of a header. It holds `start` high across that cycle and the `done` cycle that follows. The scoreboard expects exactly one extra header, starting right after `done`. Any header taken from the earlier request, or no new header at all, shows up as an unexpected or misaligned bit stream.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

    typedef enum logic [1:0] {
        RATE_2400   = 2'd0,
        RATE_9600   = 2'd1,
        RATE_19200  = 2'd2,
        RATE_19200B = 2'd3
    } rate_e;

    typedef enum logic [1:0] {
        SEG_IDLE,
        SEG_BREAK,
        SEG_SYNC,
        SEG_IDENT
    } seg_e;

    localparam int          BREAK_LOW_BITS = 13;
    localparam int          UART_BITS      = 10;
    localparam logic [7:0]  SYNC_VALUE     = 8'h55;

    // identifier with its two protection bits on top
    function automatic logic [7:0] protect_id(input logic [5:0] id);
        logic p_lo;
        logic p_hi;
        p_lo = id[0] ^ id[1] ^ id[2] ^ id[4];
        p_hi = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return {p_hi, p_lo, id};
    endfunction

    // stop bit, data, start bit: element 0 leaves the wire first
    function automatic logic [UART_BITS-1:0] uart_frame(input logic [7:0] b);
        return {1'b1, b, 1'b0};
    endfunction

endpackage

// File: rtl/lin_baud_gen.sv
module lin_baud_gen
    import lin_hdr_pkg::*;
#(
    parameter int CLK_HZ = 48_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  rate_e      rate,
    output logic       tick
);
    localparam int DIV_SLOW = CLK_HZ / 2400;
    localparam int DIV_MID  = CLK_HZ / 9600;
    localparam int DIV_FAST = CLK_HZ / 19200;
    localparam int CW       = $clog2(DIV_SLOW + 1);

    localparam logic [CW-1:0] LAST_SLOW = CW'(DIV_SLOW - 1);
    localparam logic [CW-1:0] LAST_MID  = CW'(DIV_MID - 1);
    localparam logic [CW-1:0] LAST_FAST = CW'(DIV_FAST - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last_val;

    always_comb begin
        case (rate)
            RATE_2400: last_val = LAST_SLOW;
            RATE_9600: last_val = LAST_MID;
            default:   last_val = LAST_FAST;
        endcase
    end

    assign tick = run && (cnt == last_val);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/lin_seg_shifter.sv
module lin_seg_shifter #(
    parameter int W  = 14,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [W-1:0]  load_bits,
    input  logic [LW-1:0] load_len,
    input  logic          tick,
    output logic          txd,
    output logic          last
);
    logic [W-1:0]  shreg;
    logic [LW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '1;
            remain <= '0;
        end else if (load) begin
            shreg  <= load_bits;
            remain <= load_len;
        end else if (tick && remain != '0) begin
            shreg  <= {1'b1, shreg[W-1:1]};
            remain <= remain - 1'b1;
        end
    end

    assign txd  = shreg[0];
    assign last = (remain == LW'(1));

endmodule

// File: rtl/lin_hdr_seq.sv
module lin_hdr_seq
    import lin_hdr_pkg::*;
#(
    parameter int DELIM_BITS = 1,
    parameter int W          = 14,
    parameter int LW         = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [5:0]    frame_id,
    input  logic [1:0]    baud_sel,
    input  logic          tick,
    input  logic          last,
    output logic          run,
    output rate_e         rate,
    output logic          load,
    output logic [W-1:0]  load_bits,
    output logic [LW-1:0] load_len,
    output logic          busy,
    output logic          done
);
    localparam int BRK_LEN = BREAK_LOW_BITS + DELIM_BITS;

    seg_e       seg;
    logic [5:0] id_q;
    logic       seg_end;
    logic       accept;

    assign accept  = (seg == SEG_IDLE) && start;
    assign seg_end = tick && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            seg  <= SEG_IDLE;
            id_q <= '0;
            rate <= RATE_19200;
            done <= 1'b0;
        end else begin
            done <= (seg == SEG_IDENT) && seg_end;
            if (accept) begin
                seg  <= SEG_BREAK;
                id_q <= frame_id;
                rate <= rate_e'(baud_sel);
            end else if (seg_end) begin
                case (seg)
                    SEG_BREAK: seg <= SEG_SYNC;
                    SEG_SYNC:  seg <= SEG_IDENT;
                    default:   seg <= SEG_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        load      = 1'b0;
        load_bits = '1;
        load_len  = '0;
        if (accept) begin
            load      = 1'b1;
            load_bits = {W{1'b1}} << BREAK_LOW_BITS;
            load_len  = LW'(BRK_LEN);
        end else if (seg_end && seg == SEG_BREAK) begin
            load      = 1'b1;
            load_bits = {{(W-UART_BITS){1'b1}}, uart_frame(SYNC_VALUE)};
            load_len  = LW'(UART_BITS);
        end else if (seg_end && seg == SEG_SYNC) begin
            load      = 1'b1;
            load_bits = {{(W-UART_BITS){1'b1}}, uart_frame(protect_id(id_q))};
            load_len  = LW'(UART_BITS);
        end
    end

    assign busy = (seg != SEG_IDLE);
    assign run  = busy;

endmodule

// File: rtl/lin_master_hdr_tx.sv
module lin_master_hdr_tx
    import lin_hdr_pkg::*;
#(
    parameter int CLK_HZ     = 48_000_000,
    parameter int DELIM_BITS = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] baud_sel,
    input  logic       start,
    input  logic [5:0] frame_id,
    output logic       txd,
    output logic       busy,
    output logic       done
);
    localparam int BRK_LEN = BREAK_LOW_BITS + DELIM_BITS;
    localparam int W       = (BRK_LEN > UART_BITS) ? BRK_LEN : UART_BITS;
    localparam int LW      = $clog2(W + 1);

    logic          run;
    logic          tick;
    logic          last;
    logic          load;
    logic [W-1:0]  load_bits;
    logic [LW-1:0] load_len;
    rate_e         rate;

    lin_hdr_seq #(
        .DELIM_BITS(DELIM_BITS),
        .W         (W),
        .LW        (LW)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .frame_id (frame_id),
        .baud_sel (baud_sel),
        .tick     (tick),
        .last     (last),
        .run      (run),
        .rate     (rate),
        .load     (load),
        .load_bits(load_bits),
        .load_len (load_len),
        .busy     (busy),
        .done     (done)
    );

    lin_baud_gen #(
        .CLK_HZ(CLK_HZ)
    ) u_baud (
        .clk (clk),
        .rst (rst),
        .run (run),
        .rate(rate),
        .tick(tick)
    );

    lin_seg_shifter #(
        .W (W),
        .LW(LW)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_bits(load_bits),
        .load_len (load_len),
        .tick     (tick),
        .txd      (txd),
        .last     (last)
    );

endmodule

// File: rtl/lin_hdr_tx_chk.sv
module lin_hdr_tx_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic txd,
    input logic busy,
    input logic done
);
    // R9
    idle_recessive_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R6
    busy_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R2
    first_dominant_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !txd);
endmodule

bind lin_master_hdr_tx lin_hdr_tx_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .txd  (txd),
    .busy (busy),
    .done (done)
);

// File: tb/sim_lin_master_hdr_tx.sv
module sim_lin_master_hdr_tx;

    localparam int CLK_HZ = 384_000;
    localparam int NBITS  = 34;

    typedef struct {
        logic [NBITS-1:0] bits;
        int               div;
        int               id;
    } hdr_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] baud_sel = 2'd2;
    logic       start = 1'b0;
    logic [5:0] frame_id = '0;
    logic       txd;
    logic       busy;
    logic       done;

    int   total = 0;
    int   bad   = 0;
    hdr_t expq[$];
    bit   finished = 0;

    always #2.5 clk = ~clk;

    lin_master_hdr_tx #(.CLK_HZ(CLK_HZ), .DELIM_BITS(1)) u0 (
        .clk(clk), .rst(rst), .baud_sel(baud_sel), .start(start),
        .frame_id(frame_id), .txd(txd), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int div_of(input logic [1:0] s);
        case (s)
            2'd0:    return CLK_HZ / 2400;
            2'd1:    return CLK_HZ / 9600;
            default: return CLK_HZ / 19200;
        endcase
    endfunction

    function automatic hdr_t make_hdr(input logic [5:0] id, input logic [1:0] s);
        hdr_t h;
        logic [7:0] ib;
        ib = {~(id[1] ^ id[3] ^ id[4] ^ id[5]), id[0] ^ id[1] ^ id[2] ^ id[4], id};
        h.bits = '1;
        for (int i = 0; i < 13; i++) h.bits[i] = 1'b0;
        h.bits[13] = 1'b1;
        h.bits[14] = 1'b0;
        for (int i = 0; i < 8; i++) h.bits[15+i] = 8'h55 >> i;
        h.bits[23] = 1'b1;
        h.bits[24] = 1'b0;
        for (int i = 0; i < 8; i++) h.bits[25+i] = ib[i];
        h.bits[33] = 1'b1;
        h.div = div_of(s);
        h.id  = id;
        return h;
    endfunction

    task automatic send(input logic [5:0] id, input logic [1:0] s);
        expq.push_back(make_hdr(id, s));
        @(negedge clk);
        frame_id = id;
        baud_sel = s;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy || expq.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    // monitor: compares the line against the queued headers
    initial begin
        bit   active = 0;
        int   cyc = 0;
        hdr_t cur;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (busy && !active) begin
                    if (expq.size() == 0) begin
                        check(0, "R6", "unexpected header started", 1, 0);
                        cur = make_hdr(6'd0, 2'd2);
                    end else begin
                        cur = expq.pop_front();
                    end
                    active = 1;
                    cyc = 0;
                end
                if (active) begin
                    if (busy) begin
                        if (cyc >= NBITS * cur.div) begin
                            check(0, "R7", "busy too long", cyc, NBITS * cur.div);
                        end else if ((cyc % cur.div) == 0 || (cyc % cur.div) == cur.div / 2) begin
                            int b;
                            string rq;
                            b = cyc / cur.div;
                            rq = (b < 14) ? "R2" : (b < 24) ? "R3" : "R4";
                            check(txd == cur.bits[b], rq, $sformatf("txd bit %0d id %0d R5", b, cur.id),
                                  txd, cur.bits[b]);
                            check(done == 1'b0, "R7", "done during header", done, 0);
                        end
                        cyc++;
                    end else begin
                        check(cyc == NBITS * cur.div, "R7", "busy length", cyc, NBITS * cur.div);
                        check(done == 1'b1, "R7", "done pulse", done, 1);
                        check(txd == 1'b1, "R9", "txd in done cycle", txd, 1);
                        active = 0;
                    end
                end else begin
                    check(txd == 1'b1, "R9", "idle txd", txd, 1);
                    check(done == 1'b0, "R7", "idle done", done, 0);
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        check(0, "R7", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1", "reset txd", txd, 1);
        check(busy == 1'b0, "R1", "reset busy", busy, 0);
        check(done == 1'b0, "R1", "reset done", done, 0);

        // R2 R3 R4 R5 R7: fast rate, two select codes for 19200
        send(6'h3C, 2'd2);
        wait_idle();
        send(6'h15, 2'd3);
        wait_idle();

        // R6: start and input changes during a header are ignored
        send(6'h01, 2'd1);
        repeat (300) @(negedge clk);
        frame_id = 6'h3F;
        baud_sel = 2'd0;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        wait_idle();

        // R5 slow rate
        send(6'h2A, 2'd0);
        wait_idle();

        // R8: start held over the last busy cycle and the done cycle
        send(6'h07, 2'd2);
        while (!busy) @(negedge clk);
        repeat (NBITS * div_of(2'd2) - 1) @(negedge clk);
        expq.push_back(make_hdr(6'h30, 2'd1));
        frame_id = 6'h30;
        baud_sel = 2'd1;
        start    = 1'b1;
        @(negedge clk);
        check(done == 1'b1, "R8", "done in second start cycle", done, 1);
        @(negedge clk);
        start    = 1'b0;
        check(busy == 1'b1, "R8", "back-to-back header busy", busy, 1);
        wait_idle();

        check(expq.size() == 0, "R8", "headers left unsent", expq.size(), 0);
        finish_run();
    end

endmodule